// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator. The accumulator is held as a high word and a low word. A caller picks one of two forms per operation. The long form multiplies two full 32-bit signed operands. The word form multiplies only the signed low 16 bits of each operand.

An optional saturation mode clips the result, and each form clips in its own way. The long form applies a coarse 48-bit clamp that acts only on the high word. The word form clamps to the signed 32-bit range, and when it clips it writes a marker value of one into the high word.

Software state is set up through two word loads and a clear. The result of an operation is registered and appears on the outputs one clock after the strobe.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset, both `accHi` and `accLo` read zero.
- R2: Long form with `satEn` low: both operands are sign-extended from 32 bits and their 64-bit product is added to {accHi, accLo}. The 64-bit sum wraps, and all of it is written back.
- R3: Word form with `satEn` low: only bits 15:0 of each operand are used, sign-extended. Bits 31:16 of the operands have no effect. The product is added to the 64-bit accumulator, and the wrapped sum is written back.
- R4: Long form with `satEn` high and a negative 64-bit sum (bit 63 set): bits 31:16 of the high word become all ones. All other bits of the sum are kept.
- R5: Long form with `satEn` high and a sum with bit 63 clear: the high word is ANDed with 0x00007FFF. The low word keeps the lower half of the sum.
- R6: Word form with `satEn` high and a signed sum below -2^31: accHi becomes 0x00000001 and accLo becomes 0x80000000.
- R7: Word form with `satEn` high and a signed sum above 0x7FFFFFFF: accHi becomes 0x00000001 and accLo becomes 0x7FFFFFFF.
- R8: Word form with `satEn` high and the sum inside the signed 32-bit range: both words take the sum unchanged.
- R9: A result appears on the outputs at the first rising edge after `opValid`. With no strobe active, the accumulator holds its value, and `satEn`, `opWord` and the operands have no effect.
- R10: `accClear` zeroes both words. It takes priority over `opValid`, `loadHi` and `loadLo` asserted in the same cycle.
- R11: `loadHi` writes `loadData` into the high word only, and `loadLo` writes it into the low word only. An operation in the same cycle takes priority over both loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation strobe, one cycle per operation |
| opWord | input | 1 | Form select: 1 selects the 16-bit word form, 0 selects the 32-bit long form |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| satEn | input | 1 | Saturation enable |
| accClear | input | 1 | Zero the accumulator |
| loadHi | input | 1 | Write `loadData` into the high word |
| loadLo | input | 1 | Write `loadData` into the low word |
| loadData | input | 32 | Data for the word loads |
| accHi | output | 32 | Accumulator high word |
| accLo | output | 32 | Accumulator low word |

## Verification
The bench builds the unit with its default parameters: 32-bit words, 16-bit word-form operands and a 48-bit long-form clamp. With these values the clamp masks take the exact positions that the requirements name.

The loads preset the accumulator directly at the edges of each clamp. This makes every boundary reachable in a single operation: one below -2^31, exactly 0x7FFFFFFF plus one, a carry from the low word into the high word, and a wrap at bit 63. No long chain of accumulations is needed to reach them.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  // Strobes passed from control to datapath, already prioritised.
  typedef struct packed {
    logic clr;
    logic mac;
    logic word;
    logic sat;
    logic ldHi;
    logic ldLo;
  } macCtl_t;

  localparam int DEF_WORD_W  = 32;
  localparam int DEF_HALF_W  = 16;
  localparam int DEF_CLAMP_W = 48;

endpackage

// File: rtl/sat_mac_ctrl.sv
module sat_mac_ctrl
  import sat_mac_pkg::*;
(
  input  logic    opValid,
  input  logic    opWord,
  input  logic    satEn,
  input  logic    accClear,
  input  logic    loadHi,
  input  logic    loadLo,
  output macCtl_t ctl
);

  // Priority: clear, then operation, then the word loads.
  always_comb begin
    ctl      = '0;
    ctl.clr  = accClear;
    ctl.mac  = opValid & ~accClear;
    ctl.word = opWord;
    ctl.sat  = satEn;
    ctl.ldHi = loadHi & ~accClear & ~opValid;
    ctl.ldLo = loadLo & ~accClear & ~opValid;
  end

endmodule

// File: rtl/sat_mac_clamp.sv
module sat_mac_clamp #(
  parameter int WORD_W  = 32,
  parameter int CLAMP_W = 48
) (
  input  logic [2*WORD_W-1:0] sumIn,
  input  logic                isWord,
  input  logic                satOn,
  output logic [2*WORD_W-1:0] sumOut
);

  localparam int ACC_W    = 2 * WORD_W;
  localparam int KEEP_W   = CLAMP_W - 1 - WORD_W;  // high-word bits kept when positive
  localparam int ONES_W   = ACC_W - CLAMP_W;       // high-word bits forced when negative
  localparam logic [WORD_W-1:0] POS_MASK = WORD_W'((64'd1 << KEEP_W) - 64'd1);
  localparam logic [WORD_W-1:0] NEG_FILL = ~WORD_W'((64'd1 << (WORD_W - ONES_W)) - 64'd1);
  localparam logic [ACC_W-1:0]  POS_LIM  = {{(WORD_W + 1){1'b0}}, {(WORD_W - 1){1'b1}}};
  localparam logic [ACC_W-1:0]  NEG_LIM  = {{(WORD_W + 1){1'b1}}, {(WORD_W - 1){1'b0}}};
  localparam logic [WORD_W-1:0] MARK_HI  = WORD_W'(1);

  logic [WORD_W-1:0] sumHi;
  logic [WORD_W-1:0] sumLo;
  logic              sumNeg;
  logic              overTop;
  logic              underBot;

  assign sumHi    = sumIn[ACC_W-1:WORD_W];
  assign sumLo    = sumIn[WORD_W-1:0];
  assign sumNeg   = sumIn[ACC_W-1];
  assign overTop  = $signed(sumIn) > $signed(POS_LIM);
  assign underBot = $signed(sumIn) < $signed(NEG_LIM);

  always_comb begin
    sumOut = sumIn;
    if (satOn) begin
      if (!isWord) begin
        if (sumNeg) sumOut = {sumHi | NEG_FILL, sumLo};
        else        sumOut = {sumHi & POS_MASK, sumLo};
      end else if (underBot) begin
        sumOut = {MARK_HI, NEG_LIM[WORD_W-1:0]};
      end else if (overTop) begin
        sumOut = {MARK_HI, POS_LIM[WORD_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/sat_mac_dp.sv
module sat_mac_dp
  import sat_mac_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int HALF_W  = 16,
  parameter int CLAMP_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  macCtl_t           ctl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] accHi,
  output logic [WORD_W-1:0] accLo
);

  localparam int ACC_W = 2 * WORD_W;

  logic [ACC_W-1:0] longA, longB, wordA, wordB;
  logic [ACC_W-1:0] mulA, mulB, product, rawSum, clipSum;

  // Sign extension for each form.
  assign longA = {{WORD_W{opA[WORD_W-1]}}, opA};
  assign longB = {{WORD_W{opB[WORD_W-1]}}, opB};
  assign wordA = {{(ACC_W - HALF_W){opA[HALF_W-1]}}, opA[HALF_W-1:0]};
  assign wordB = {{(ACC_W - HALF_W){opB[HALF_W-1]}}, opB[HALF_W-1:0]};

  assign mulA    = ctl.word ? wordA : longA;
  assign mulB    = ctl.word ? wordB : longB;
  assign product = mulA * mulB;            // low ACC_W bits of the signed product
  assign rawSum  = {accHi, accLo} + product;

  sat_mac_clamp #(
    .WORD_W (WORD_W),
    .CLAMP_W(CLAMP_W)
  ) uClamp (
    .sumIn (rawSum),
    .isWord(ctl.word),
    .satOn (ctl.sat),
    .sumOut(clipSum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi <= '0;
      accLo <= '0;
    end else if (ctl.clr) begin
      accHi <= '0;
      accLo <= '0;
    end else if (ctl.mac) begin
      accHi <= clipSum[ACC_W-1:WORD_W];
      accLo <= clipSum[WORD_W-1:0];
    end else begin
      if (ctl.ldHi) accHi <= loadData;
      if (ctl.ldLo) accLo <= loadData;
    end
  end

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int WORD_W  = DEF_WORD_W,
  parameter int HALF_W  = DEF_HALF_W,
  parameter int CLAMP_W = DEF_CLAMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opWord,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              satEn,
  input  logic              accClear,
  input  logic              loadHi,
  input  logic              loadLo,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] accHi,
  output logic [WORD_W-1:0] accLo
);

  macCtl_t ctl;

  sat_mac_ctrl uCtrl (
    .opValid (opValid),
    .opWord  (opWord),
    .satEn   (satEn),
    .accClear(accClear),
    .loadHi  (loadHi),
    .loadLo  (loadLo),
    .ctl     (ctl)
  );

  sat_mac_dp #(
    .WORD_W (WORD_W),
    .HALF_W (HALF_W),
    .CLAMP_W(CLAMP_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .loadData(loadData),
    .accHi   (accHi),
    .accLo   (accLo)
  );

endmodule

// File: rtl/sat_mac_checker.sv
module sat_mac_checker #(
  parameter int WORD_W  = 32,
  parameter int CLAMP_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              opWord,
  input logic              satEn,
  input logic              accClear,
  input logic              loadHi,
  input logic              loadLo,
  input logic [WORD_W-1:0] loadData,
  input logic [WORD_W-1:0] accHi,
  input logic [WORD_W-1:0] accLo
);

  localparam int ONES_W = 2 * WORD_W - CLAMP_W;
  localparam int KEEP_W = CLAMP_W - 1 - WORD_W;

  // R10: clear leaves both words at zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    accClear |=> (accHi == '0 && accLo == '0));

  // R9: idle cycles hold the accumulator
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !accClear && !loadHi && !loadLo) |=> ($stable(accHi) && $stable(accLo)));

  // R4, R5: long-form saturated high word is either negative-filled or masked
  p_long_clamp_r4_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opWord && satEn && !accClear) |=>
      ((accHi[WORD_W-1:WORD_W-ONES_W] == '1) || (accHi[WORD_W-1:KEEP_W] == '0)));

  // R6, R7, R8: word-form saturated result is a marker or a sign-extended 32-bit value
  p_word_clamp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opWord && satEn && !accClear) |=>
      ((accHi == WORD_W'(1)) || (accHi == {WORD_W{accLo[WORD_W-1]}})));

  // R11: a lone high load carries the data and leaves the low word alone
  p_load_hi_r11: assert property (@(posedge clk) disable iff (!rstN)
    (loadHi && !loadLo && !opValid && !accClear) |=>
      (accHi == $past(loadData) && $stable(accLo)));

endmodule

bind sat_mac_unit sat_mac_checker #(
  .WORD_W (WORD_W),
  .CLAMP_W(CLAMP_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opWord  (opWord),
  .satEn   (satEn),
  .accClear(accClear),
  .loadHi  (loadHi),
  .loadLo  (loadLo),
  .loadData(loadData),
  .accHi   (accHi),
  .accLo   (accLo)
);

// File: tb/sat_mac_unit_test.sv
module sat_mac_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {preHi, preLo, word, sat, a, b}
  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
    logic        word;
    logic        sat;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0, 32'h0, 1'b0, 1'b0, 32'd7, 32'hFFFF_FFFD},                    // R2 small signed
    '{32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'd1, 32'd1},                    // R2 carry into high
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'd1, 32'd1},            // R2 wrap at bit 63
    '{32'h0, 32'h0, 1'b1, 1'b0, 32'hABCD_8000, 32'h1234_0002},            // R3 upper bits ignored
    '{32'h0, 32'h0, 1'b1, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF},            // R3 -1 * -1
    '{32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFF_FFFB, 32'd100},                  // R4 negative fill
    '{32'hFFFF_1234, 32'h0, 1'b0, 1'b1, 32'd0, 32'd0},                    // R4 already filled
    '{32'h1234_5678, 32'h0, 1'b0, 1'b1, 32'd1, 32'd1},                    // R5 mask high word
    '{32'h0, 32'h0, 1'b0, 1'b1, 32'h4000_0000, 32'h4000_0000},            // R5 product 2^60
    '{32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b1, 32'h0000_FFFF, 32'd1},    // R6 one below -2^31
    '{32'h0, 32'h7FFF_FFFF, 1'b1, 1'b1, 32'd1, 32'd1},                    // R7 one above max
    '{32'h1, 32'h0, 1'b1, 1'b1, 32'd1, 32'd1},                            // R7 far above
    '{32'h0, 32'h10, 1'b1, 1'b1, 32'h7FFF, 32'h7FFF},                     // R8 positive in range
    '{32'hFFFF_FFFF, 32'hFFFF_FFF0, 1'b1, 1'b1, 32'd2, 32'd3}             // R8 negative in range
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0, opWord = 1'b0, satEn = 1'b0;
  logic        accClear = 1'b0, loadHi = 1'b0, loadLo = 1'b0;
  logic [31:0] opA = '0, opB = '0, loadData = '0;
  logic [31:0] accHi, accLo;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sat_mac_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opWord(opWord),
    .opA(opA), .opB(opB), .satEn(satEn), .accClear(accClear),
    .loadHi(loadHi), .loadLo(loadLo), .loadData(loadData),
    .accHi(accHi), .accLo(accLo)
  );

  // Reference written from the requirements.
  function automatic logic [63:0] refMac(input logic [31:0] hi, input logic [31:0] lo,
                                         input logic word, input logic sat,
                                         input logic [31:0] a, input logic [31:0] b);
    longint acc, prod, s;
    logic [31:0] h, l;
    acc = longint'({hi, lo});
    if (word) prod = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
    else      prod = longint'(int'(a)) * longint'(int'(b));
    s = acc + prod;
    h = s[63:32];
    l = s[31:0];
    if (sat && !word) begin
      if (s < 0) h = h | 32'hFFFF_0000;
      else       h = h & 32'h0000_7FFF;
    end else if (sat && word) begin
      if (s < -64'sd2147483648)     begin h = 32'd1; l = 32'h8000_0000; end
      else if (s > 64'sd2147483647) begin h = 32'd1; l = 32'h7FFF_FFFF; end
    end
    return {h, l};
  endfunction

  task automatic check(input string tag, input logic [31:0] expHi, input logic [31:0] expLo);
    nChecks++;
    if (accHi !== expHi || accLo !== expLo) begin
      nFails++;
      $display("FAIL %s: got %h_%h expected %h_%h", tag, accHi, accLo, expHi, expLo);
    end
  endtask

  task automatic idleInputs();
    opValid = 0; accClear = 0; loadHi = 0; loadLo = 0;
  endtask

  task automatic preset(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk); idleInputs(); loadHi = 1; loadData = hi;
    @(negedge clk); loadHi = 0; loadLo = 1; loadData = lo;
    @(negedge clk); loadLo = 0;
  endtask

  task automatic doOp(input logic word, input logic sat, input logic [31:0] a, input logic [31:0] b);
    idleInputs(); opValid = 1; opWord = word; satEn = sat; opA = a; opB = b;
    @(negedge clk); opValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] e;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 32'h0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", 32'h0, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      preset(VECS[i].hi, VECS[i].lo);
      doOp(VECS[i].word, VECS[i].sat, VECS[i].a, VECS[i].b);
      e = refMac(VECS[i].hi, VECS[i].lo, VECS[i].word, VECS[i].sat, VECS[i].a, VECS[i].b);
      check($sformatf("vector %0d", i), e[63:32], e[31:0]);
    end

    // R9: one-cycle latency, then hold while idle with other inputs moving
    preset(32'h0, 32'h5);
    idleInputs(); opValid = 1; opWord = 0; satEn = 0; opA = 32'd3; opB = 32'd4;
    @(posedge clk); #1;
    opValid = 0;
    check("R9 latency", 32'h0, 32'd17);
    satEn = 1; opWord = 1; opA = 32'hFFFF_FFFF; opB = 32'h8000_0000;
    repeat (3) @(negedge clk);
    check("R9 idle hold", 32'h0, 32'd17);

    // R10: clear wins over op and loads together
    preset(32'hDEAD_BEEF, 32'h1234_5678);
    idleInputs(); accClear = 1; opValid = 1; loadHi = 1; loadLo = 1; loadData = 32'hFFFF_FFFF;
    opWord = 0; satEn = 0; opA = 32'd9; opB = 32'd9;
    @(negedge clk); idleInputs();
    check("R10 clear priority", 32'h0, 32'h0);

    // R11: loads are independent
    preset(32'hAAAA_0000, 32'h0000_5555);
    loadHi = 1; loadData = 32'h0BAD_F00D;
    @(negedge clk); loadHi = 0;
    check("R11 hi load only", 32'h0BAD_F00D, 32'h0000_5555);
    loadLo = 1; loadData = 32'h1357_9BDF;
    @(negedge clk); loadLo = 0;
    check("R11 lo load only", 32'h0BAD_F00D, 32'h1357_9BDF);

    // R11: operation beats a simultaneous load
    preset(32'h0, 32'h0);
    idleInputs(); opValid = 1; opWord = 0; satEn = 0; opA = 32'd6; opB = 32'd7;
    loadHi = 1; loadLo = 1; loadData = 32'hFFFF_FFFF;
    @(negedge clk); idleInputs();
    check("R11 op over load", 32'h0, 32'd42);

    // R2: back-to-back accumulation
    doOp(1'b0, 1'b0, 32'hFFFF_FFFF, 32'd50);
    check("R2 accumulate", 32'hFFFF_FFFF, 32'hFFFF_FFF8);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule